// File: doc/BRIEF.md
# Flash Write-Buffer Load Sequencer

This block steps a host through buffered programming of a flash model. The host writes a buffer-setup command, and the block answers through an availability bit in its extended status. If the program engine is still busy, that bit reads 0 and the host repeats the setup command until it reads 1. The host then writes an item count, encoded as N-1. After that comes the start address with the first data item, followed by further address/data writes until N items have arrived.

Each later address must fall inside the window that runs from the start address to the start address plus the encoded count. The block stores each item in a local buffer at the offset of its address from the start. It flags a start address whose low five bits are zero as buffer-aligned. A final confirm write either passes the buffer to the program engine or aborts the sequence with error status.

The engine reads the loaded items through a combinational read port, using the offset as the index. It also receives the start address and the encoded count. The engine keeps its busy input high while it works.

Top module: `fwb_loader`

## Requirements
- R1: After reset, `xsr_avail`, `seq_err`, `prog_err`, `aligned` and `prog_go` are all 0.
- R2: A setup write (data 0xE8) in the idle phase while `eng_busy` is 1 makes `xsr_avail` 0 in the next cycle and leaves the sequence idle, so a later count, data and confirm do not raise `prog_go`.
- R3: A setup write while `eng_busy` is 0 sets `xsr_avail` to 1 and clears `seq_err` and `prog_err` in the next cycle, and the next write is taken as the count.
- R4: A count write whose value exceeds 31 (the buffer holds 32 items) sets `seq_err` and returns the sequence to idle.
- R5: The write after the count stores its data at offset 0 and records its address as the start. Each later item is stored at offset (address - start), and the engine reads offset k on `rd_data` when `rd_idx` = k.
- R6: A data write whose address lies outside start..start+count (wrapping modulo 2^AW) sets `seq_err`, aborts the sequence, and leaves `xsr_avail` at 1.
- R7: `aligned` becomes 1 when the start address has bits [4:0] equal to 0, and 0 otherwise.
- R8: After count+1 items, a confirm write of 0xD0 pulses `prog_go` high for exactly one cycle, with `prog_start` equal to the start address and `prog_cnt` equal to the encoded count.
- R9: Any other value in the confirm slot sets both `prog_err` and `seq_err` and does not raise `prog_go`.
- R10: In the idle phase, writes whose data is not 0xE8 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one item per cycle |
| wr_addr | input | AW | Host write address |
| wr_data | input | DW | Host write data or command code |
| eng_busy | input | 1 | Program engine is using the buffer |
| xsr_avail | output | 1 | Extended status: buffer available |
| seq_err | output | 1 | Sequence error status |
| prog_err | output | 1 | Program error status |
| aligned | output | 1 | Start address is buffer-aligned |
| prog_go | output | 1 | One-cycle start pulse to the engine |
| prog_start | output | AW | Start address handed to the engine |
| prog_cnt | output | IW | Encoded item count (N-1) |
| rd_idx | input | IW | Engine read offset |
| rd_data | output | DW | Buffer item at `rd_idx` |

## Verification
The hardest state to reach is a complete buffered sequence in which repeated and out-of-order offsets overwrite earlier items, followed by a confirm. Reaching it needs the setup retry to have succeeded, a legal count, and every address kept inside the window. The stimulus gets there with randomized start addresses, counts and offsets that are always drawn from within the window. It also raises `eng_busy` at random, which forces the retry loop. After each confirm it reads back the whole buffer and compares it with a model in which the last write to each offset wins.

// File: rtl/fwb_loader.sv
module fwb_loader #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int BUF_ITEMS = 32,
  parameter logic [7:0] SETUP_CMD = 8'hE8,
  parameter logic [7:0] GO_CMD = 8'hD0,
  parameter int IW = $clog2(BUF_ITEMS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          eng_busy,
  output logic          xsr_avail,
  output logic          seq_err,
  output logic          prog_err,
  output logic          aligned,
  output logic          prog_go,
  output logic [AW-1:0] prog_start,
  output logic [IW-1:0] prog_cnt,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);

  typedef enum logic [2:0] {S_IDLE, S_CNT, S_FIRST, S_DATA, S_CONF} phase_t;

  phase_t        ph;
  logic [IW-1:0] left;
  logic [DW-1:0] mem [BUF_ITEMS];

  wire [7:0]    cmd    = wr_data[7:0];
  wire [AW-1:0] off    = wr_addr - prog_start;
  wire          in_win = off <= AW'(prog_cnt);
  wire          big    = wr_data > DW'(BUF_ITEMS - 1);
  wire          store  = wr_en && (ph == S_FIRST || (ph == S_DATA && in_win));
  wire [IW-1:0] widx   = (ph == S_FIRST) ? '0 : off[IW-1:0];

  assign rd_data = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (store) mem[widx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph         <= S_IDLE;
      xsr_avail  <= 1'b0;
      seq_err    <= 1'b0;
      prog_err   <= 1'b0;
      aligned    <= 1'b0;
      prog_go    <= 1'b0;
      prog_start <= '0;
      prog_cnt   <= '0;
      left       <= '0;
    end else begin
      prog_go <= 1'b0;
      if (wr_en) begin
        case (ph)
          S_IDLE: if (cmd == SETUP_CMD) begin
            xsr_avail <= !eng_busy;
            seq_err   <= 1'b0;
            prog_err  <= 1'b0;
            if (!eng_busy) ph <= S_CNT;
          end
          S_CNT: if (big) begin
            seq_err <= 1'b1;
            ph      <= S_IDLE;
          end else begin
            prog_cnt <= wr_data[IW-1:0];
            ph       <= S_FIRST;
          end
          S_FIRST: begin
            prog_start <= wr_addr;
            aligned    <= wr_addr[IW-1:0] == '0;
            left       <= prog_cnt;
            ph         <= (prog_cnt == '0) ? S_CONF : S_DATA;
          end
          S_DATA: if (!in_win) begin
            seq_err <= 1'b1;
            ph      <= S_IDLE;
          end else begin
            left <= left - 1'b1;
            if (left == IW'(1)) ph <= S_CONF;
          end
          S_CONF: begin
            if (cmd == GO_CMD) prog_go <= 1'b1;
            else begin
              prog_err <= 1'b1;
              seq_err  <= 1'b1;
            end
            ph <= S_IDLE;
          end
          default: ph <= S_IDLE;
        endcase
      end
    end
  end

  AST_GO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) prog_go |=> !prog_go); // R8
  AST_GO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) prog_go |-> (xsr_avail && !seq_err && !prog_err)); // R9
  AST_PERR_WITH_SERR: assert property (@(posedge clk) disable iff (!rst_n) prog_err |-> seq_err); // R9
  AST_BUSY_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ph == S_IDLE && cmd == SETUP_CMD && eng_busy) |=> (!xsr_avail && ph == S_IDLE)); // R2
  AST_FREE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ph == S_IDLE && cmd == SETUP_CMD && !eng_busy) |=> (xsr_avail && !seq_err && ph == S_CNT)); // R3
  AST_BIG_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ph == S_CNT && big) |=> (seq_err && ph == S_IDLE)); // R4
  AST_WINDOW_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ph == S_DATA && !in_win) |=> (seq_err && xsr_avail && ph == S_IDLE)); // R6
  AST_IDLE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ph == S_IDLE && cmd != SETUP_CMD) |=> ($stable(xsr_avail) && $stable(seq_err) && ph == S_IDLE)); // R10

endmodule

// File: tb/fwb_loader_bench.sv
module fwb_loader_bench;
  localparam int AW = 16, DW = 8, IW = 5;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, eng_busy = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [IW-1:0] rd_idx = '0;
  logic xsr_avail, seq_err, prog_err, aligned, prog_go;
  logic [AW-1:0] prog_start;
  logic [IW-1:0] prog_cnt;
  logic [DW-1:0] rd_data;

  int total = 0, bad = 0;
  logic [DW-1:0] model [32];

  always #2 clk = ~clk;

  fwb_loader u_fwb_loader (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .eng_busy(eng_busy), .xsr_avail(xsr_avail), .seq_err(seq_err), .prog_err(prog_err),
    .aligned(aligned), .prog_go(prog_go), .prog_start(prog_start), .prog_cnt(prog_cnt),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  function automatic bit exp_aligned(input logic [AW-1:0] a);
    return a[4:0] == 5'd0;
  endfunction

  function automatic bit exp_in_window(input logic [AW-1:0] a, input logic [AW-1:0] s, input int c);
    logic [AW-1:0] d;
    d = a - s;
    return int'(d) <= c;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_buffer(input int c, input string req);
    for (int k = 0; k <= c; k++) begin
      rd_idx = IW'(k);
      #1;
      chk(rd_data == model[k], req, rd_data, model[k]);
    end
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] st, a;
    int c;
    void'($urandom(32'd5521));
    repeat (3) @(negedge clk);
    chk({xsr_avail, seq_err, prog_err, aligned, prog_go} == 5'b0, "R1 reset state",
        {xsr_avail, seq_err, prog_err, aligned, prog_go}, 0);
    rst_n = 1'b1;

    // R10: non-setup data in idle ignored
    wr(16'h0100, 8'h04); wr(16'h0100, 8'hD0); wr(16'h0100, 8'h40);
    chk(!prog_go && !xsr_avail && !seq_err, "R10 idle ignores other data", {prog_go, xsr_avail, seq_err}, 0);

    // R2: busy setup
    eng_busy = 1'b1;
    wr(16'h0100, 8'hE8);
    chk(!xsr_avail, "R2 avail reads 0 while busy", xsr_avail, 0);
    eng_busy = 1'b0;
    wr(16'h0100, 8'h00); wr(16'h0100, 8'h11); wr(16'h0100, 8'hD0);
    chk(!prog_go, "R2 sequence stays idle", prog_go, 0);

    // R4: count too large, after an R3 setup
    wr(16'h0100, 8'hE8);
    chk(xsr_avail && !seq_err, "R3 setup grants buffer", {xsr_avail, seq_err}, 2);
    wr(16'h0100, 8'd32);
    chk(seq_err, "R4 count 32 rejected", seq_err, 1);
    wr(16'h0100, 8'hE8);
    chk(!seq_err && !prog_err, "R3 setup clears errors", {seq_err, prog_err}, 0);

    // Full 32-item aligned load, R5/R7/R8
    wr(16'h0200, 8'd31);
    for (int k = 0; k < 32; k++) begin
      model[k] = 8'(k * 7 + 3);
      wr(16'h0200 + 16'(k), model[k]);
      if (k == 0) chk(aligned, "R7 aligned start flagged", aligned, 1);
    end
    wr(16'h0200, 8'hD0);
    chk(prog_go && prog_start == 16'h0200 && prog_cnt == 5'd31, "R8 confirm starts program",
        {prog_go, prog_start, prog_cnt}, {1'b1, 16'h0200, 5'd31});
    @(negedge clk);
    chk(!prog_go, "R8 go lasts one cycle", prog_go, 0);
    check_buffer(31, "R5 full buffer readback");

    // R7 unaligned start, R6 address above the window
    wr(16'h0123, 8'hE8); wr(16'h0123, 8'd3); wr(16'h0123, 8'hAA);
    chk(!aligned, "R7 unaligned start", aligned, 0);
    wr(16'h0127, 8'hBB);
    chk(seq_err && xsr_avail, "R6 address above window aborts", {seq_err, xsr_avail}, 3);
    wr(16'h0124, 8'hD0);
    chk(!prog_go, "R6 no program after abort", prog_go, 0);

    // R6 address below start
    wr(16'h0300, 8'hE8); wr(16'h0300, 8'd2); wr(16'h0305, 8'h01);
    wr(16'h0304, 8'h02);
    chk(seq_err, "R6 address below start aborts", seq_err, 1);

    // R9 bad confirm, single item (count 0)
    wr(16'h0400, 8'hE8); wr(16'h0400, 8'd0); wr(16'h0400, 8'h5A);
    wr(16'h0400, 8'hFF);
    chk(prog_err && seq_err && !prog_go, "R9 bad confirm", {prog_err, seq_err, prog_go}, 6);

    // Random sequences with busy retry and overlapping offsets
    for (int it = 0; it < 60; it++) begin
      st = 16'($urandom_range(0, 16'hEFFF));
      if ($urandom_range(0, 3) == 0) st[4:0] = 5'd0;
      c = $urandom_range(0, 31);
      eng_busy = ($urandom_range(0, 3) == 0);
      wr(st, 8'hE8);
      while (!xsr_avail) begin
        chk(eng_busy, "R2 unavailable only when busy", eng_busy, 1);
        eng_busy = 1'b0;
        wr(st, 8'hE8);
      end
      wr(st, 8'(c));
      model[0] = 8'($urandom);
      wr(st, model[0]);
      chk(aligned == exp_aligned(st), "R7 random alignment", aligned, exp_aligned(st));
      for (int k = 1; k <= c; k++) begin
        a = st + 16'($urandom_range(0, c));
        if (exp_in_window(a, st, c)) begin
          model[a - st] = 8'($urandom);
          wr(a, model[a - st]);
        end
      end
      wr(st, 8'hD0);
      chk(prog_go && prog_start == st && int'(prog_cnt) == c && !seq_err, "R8 random confirm",
          {prog_go, prog_start, prog_cnt}, {1'b1, st, 5'(c)});
      check_buffer(c, "R5 random readback");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule